// File: doc/BRIEF.md
# Interval Timer Command Port Decoder

This block sits between a simple byte-wide register bus and the three counter channels of a programmable interval timer. It owns four consecutive byte ports: three channel data ports followed by one command port. Writes to a data port are passed to the addressed channel as a one-cycle write strobe with the captured byte. Reads of a data port raise a one-cycle read strobe and return that channel's byte. Reads of the command port always return zero.

A byte written to the command port is a control word that can mean one of three things. With a channel selected in the top two bits and a non-zero access field, it reprograms that channel's mode, access order and BCD flag. With a zero access field, it only freezes that channel's current count. With the top two bits both set, it is a read-back request. A read-back request may freeze the count or the status of any subset of the three channels in a single write. The decoder turns each word into one-hot per-channel pulses and forwards the mode fields that go with a program pulse.

Top module: `tcd_top`

## Requirements
- R1: After synchronous reset, every strobe output is 0, and `rdata`, `mode_out`, `access_out` and `bcd_out` are 0.
- R2: A command-port write with bits 7:6 = 0, 1 or 2 and bits 5:4 non-zero pulses `prog_stb[n]` for channel n = bits 7:6 on the cycle after the write. On that cycle it also loads `access_out` = bits 5:4, `mode_out` = bits 3:1 and `bcd_out` = bit 0.
- R3: Mode values 6 and 7 are forwarded on `mode_out` as 2 and 3; all other mode values pass unchanged.
- R4: A command-port write with bits 7:6 = 0..2 and bits 5:4 = 00 pulses only `latch_cnt_stb[n]`. It leaves `mode_out`, `access_out` and `bcd_out` unchanged.
- R5: A command-port write with bits 7:6 = 3 and bits 5:4 = 01 pulses `latch_cnt_stb` for every channel whose select bit is set. Bit 1 selects channel 0, bit 2 selects channel 1 and bit 3 selects channel 2.
- R6: A command-port write with bits 7:6 = 3 and bits 5:4 = 10 pulses `latch_sts_stb` for the channels selected by bits 3:1, using the same mapping as R5.
- R7: A read-back word whose bits 5:4 are 00 or 11 produces no strobe and changes no field output.
- R8: A write to offset 0x40, 0x41 or 0x42 pulses `data_wr_stb` for channel 0, 1 or 2 respectively and presents the written byte on `data_out` on the following cycle.
- R9: A read of offset 0x40..0x42 pulses `data_rd_stb` for that channel, and `rdata` then holds that channel's byte from `chan_rdata`. Channel n occupies bits 8n+7:8n.
- R10: A read of the command port at 0x43 returns 0 on `rdata` and raises no strobe.
- R11: A read or write to any other address raises no strobe and leaves the field outputs unchanged; a read of such an address returns 0.
- R12: Every strobe is a single-cycle pulse that appears only on the cycle after an access. A cycle with no access leaves all strobes at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle byte write strobe |
| rd_en | input | 1 | Single-cycle byte read strobe |
| addr | input | 8 | Port address |
| wdata | input | 8 | Write byte |
| chan_rdata | input | 24 | Read bytes from the three channels, channel n at bits 8n+7:8n |
| rdata | output | 8 | Registered read byte |
| prog_stb | output | 3 | One-hot per-channel program pulse |
| latch_cnt_stb | output | 3 | Per-channel count-freeze pulses |
| latch_sts_stb | output | 3 | Per-channel status-freeze pulses |
| mode_out | output | 3 | Operating mode of the last program word, folded |
| access_out | output | 2 | Access order of the last program word |
| bcd_out | output | 1 | BCD flag of the last program word |
| data_wr_stb | output | 3 | One-hot per-channel data write pulse |
| data_rd_stb | output | 3 | One-hot per-channel data read pulse |
| data_out | output | 8 | Captured data-port write byte |

## Verification
The embedded assertions check four things on every cycle. Program and data strobes are never more than one-hot. No strobe appears on a cycle that was not preceded by a write or read. A freeze word never disturbs the forwarded mode fields. A command-port read always yields zero. Only the bench's scenarios can show that each word maps to the correct channel set, including multi-channel read-back and the 6/7 mode fold, and that data bytes land on the right channel.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  // access field of a control word
  typedef enum logic [1:0] {
    ACC_FREEZE = 2'b00,
    ACC_LOW    = 2'b01,
    ACC_HIGH   = 2'b10,
    ACC_WORD   = 2'b11
  } acc_e;

  localparam logic [1:0] SEL_MULTI   = 2'b11;
  localparam logic [1:0] RB_COUNT    = 2'b01;
  localparam logic [1:0] RB_STATUS   = 2'b10;
  localparam int         CW_W        = 8;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;

  // modes 6 and 7 alias modes 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
  endfunction

endpackage

// File: rtl/tcd_addr_decode.sv
module tcd_addr_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_CH    = 3,
  parameter int BASE_ADDR = 'h40
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] data_hit,
  output logic              cmd_hit
);
  localparam logic [ADDR_W-1:0] CMD_PORT = ADDR_W'(BASE_ADDR + NUM_CH);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_port
    localparam logic [ADDR_W-1:0] PORT = ADDR_W'(BASE_ADDR + ch);
    assign data_hit[ch] = (addr == PORT);
  end

  assign cmd_hit = (addr == CMD_PORT);
endmodule

// File: rtl/tcd_word_decode.sv
module tcd_word_decode
  import tcd_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic               en,
  input  logic [CW_W-1:0]    word,
  output logic [NUM_CH-1:0]  prog,
  output logic [NUM_CH-1:0]  freeze_cnt,
  output logic [NUM_CH-1:0]  freeze_sts
);
  ctrl_word_t cw;
  logic       multi, direct, is_freeze;

  assign cw        = ctrl_word_t'(word);
  assign multi     = en && (cw.sel == SEL_MULTI);
  assign direct    = en && (cw.sel != SEL_MULTI);
  assign is_freeze = (acc_e'(cw.acc) == ACC_FREEZE);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit, rb_sel;
    assign hit = direct && (cw.sel == 2'(ch));
    if (ch < 3) begin : g_rb
      assign rb_sel = multi && word[ch+1];
    end else begin : g_norb
      assign rb_sel = 1'b0;
    end
    assign prog[ch]       = hit && !is_freeze;
    assign freeze_cnt[ch] = (hit && is_freeze) || (rb_sel && cw.acc == RB_COUNT);
    assign freeze_sts[ch] = rb_sel && (cw.acc == RB_STATUS);
  end
endmodule

// File: rtl/tcd_top.sv
module tcd_top
  import tcd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_CH    = 3,
  parameter int BASE_ADDR = 'h40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_CH*DATA_W-1:0] chan_rdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_CH-1:0]        prog_stb,
  output logic [NUM_CH-1:0]        latch_cnt_stb,
  output logic [NUM_CH-1:0]        latch_sts_stb,
  output logic [2:0]               mode_out,
  output logic [1:0]               access_out,
  output logic                     bcd_out,
  output logic [NUM_CH-1:0]        data_wr_stb,
  output logic [NUM_CH-1:0]        data_rd_stb,
  output logic [DATA_W-1:0]        data_out
);
  localparam logic [ADDR_W-1:0] CMD_PORT = ADDR_W'(BASE_ADDR + NUM_CH);

  logic [NUM_CH-1:0] data_hit;
  logic              cmd_hit;
  logic [NUM_CH-1:0] prog_n, fcnt_n, fsts_n;
  logic [DATA_W-1:0] rd_mux;
  ctrl_word_t        cw;

  tcd_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE_ADDR(BASE_ADDR)) u_addr (
    .addr(addr), .data_hit(data_hit), .cmd_hit(cmd_hit)
  );

  tcd_word_decode #(.NUM_CH(NUM_CH)) u_word (
    .en(wr_en && cmd_hit), .word(wdata[CW_W-1:0]),
    .prog(prog_n), .freeze_cnt(fcnt_n), .freeze_sts(fsts_n)
  );

  assign cw = ctrl_word_t'(wdata[CW_W-1:0]);

  always_comb begin
    rd_mux = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (data_hit[ch]) rd_mux = chan_rdata[ch*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_stb      <= '0;
      latch_cnt_stb <= '0;
      latch_sts_stb <= '0;
      data_wr_stb   <= '0;
      data_rd_stb   <= '0;
      mode_out      <= '0;
      access_out    <= '0;
      bcd_out       <= 1'b0;
      data_out      <= '0;
      rdata         <= '0;
    end else begin
      prog_stb      <= prog_n;
      latch_cnt_stb <= fcnt_n;
      latch_sts_stb <= fsts_n;
      data_wr_stb   <= wr_en ? data_hit : '0;
      data_rd_stb   <= rd_en ? data_hit : '0;
      if (|prog_n) begin
        mode_out   <= fold_mode(cw.mode);
        access_out <= cw.acc;
        bcd_out    <= cw.bcd;
      end
      if (wr_en && |data_hit) data_out <= wdata;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R2 / R8 / R9: at most one channel per program or data access
  a_r2_prog_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prog_stb));
  a_r8_data_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(data_wr_stb) && $onehot0(data_rd_stb));

  // R12: no strobe without an access on the previous cycle
  a_r12_no_idle_strobe: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en) |=> (prog_stb == '0 && latch_cnt_stb == '0 &&
                            latch_sts_stb == '0 && data_wr_stb == '0 && data_rd_stb == '0));

  // R4: a freeze word keeps the forwarded fields
  a_r4_freeze_keeps_fields: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CMD_PORT && wdata[7:6] != SEL_MULTI && wdata[5:4] == 2'b00)
      |=> $stable({mode_out, access_out, bcd_out}));

  // R10: command-port read yields zero
  a_r10_cmd_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == CMD_PORT) |=> (rdata == '0));

endmodule

// File: tb/tcd_top_bench.sv
module tcd_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [23:0] chan_rdata = '0;
  logic [7:0]  rdata, data_out;
  logic [2:0]  prog_stb, latch_cnt_stb, latch_sts_stb, data_wr_stb, data_rd_stb, mode_out;
  logic [1:0]  access_out;
  logic        bcd_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tcd_top u_tcd_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .chan_rdata(chan_rdata), .rdata(rdata), .prog_stb(prog_stb),
    .latch_cnt_stb(latch_cnt_stb), .latch_sts_stb(latch_sts_stb), .mode_out(mode_out),
    .access_out(access_out), .bcd_out(bcd_out), .data_wr_stb(data_wr_stb),
    .data_rd_stb(data_rd_stb), .data_out(data_out)
  );

  // {req, addr, wdata, prog, freeze_cnt, freeze_sts, mode, access, bcd}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {4'd2,  8'h43, 8'h34, 3'b001, 3'b000, 3'b000, 3'd2, 2'd3, 1'b0}, // R2 ch0 word mode 2
    {4'd2,  8'h43, 8'h71, 3'b010, 3'b000, 3'b000, 3'd0, 2'd3, 1'b1}, // R2 ch1 bcd
    {4'd3,  8'h43, 8'h9C, 3'b100, 3'b000, 3'b000, 3'd2, 2'd1, 1'b0}, // R3 mode 6 -> 2
    {4'd3,  8'h43, 8'h2E, 3'b001, 3'b000, 3'b000, 3'd3, 2'd2, 1'b0}, // R3 mode 7 -> 3
    {4'd4,  8'h43, 8'h40, 3'b000, 3'b010, 3'b000, 3'd3, 2'd2, 1'b0}, // R4 freeze ch1
    {4'd5,  8'h43, 8'hD6, 3'b000, 3'b011, 3'b000, 3'd3, 2'd2, 1'b0}, // R5 count ch0+ch1
    {4'd6,  8'h43, 8'hEE, 3'b000, 3'b000, 3'b111, 3'd3, 2'd2, 1'b0}, // R6 status all
    {4'd7,  8'h43, 8'hCE, 3'b000, 3'b000, 3'b000, 3'd3, 2'd2, 1'b0}, // R7 rb 00
    {4'd7,  8'h43, 8'hFE, 3'b000, 3'b000, 3'b000, 3'd3, 2'd2, 1'b0}, // R7 rb 11
    {4'd4,  8'h43, 8'h0A, 3'b000, 3'b001, 3'b000, 3'd3, 2'd2, 1'b0}, // R4 freeze ch0, mode bits ignored
    {4'd11, 8'h44, 8'h34, 3'b000, 3'b000, 3'b000, 3'd3, 2'd2, 1'b0}, // R11 unmapped write
    {4'd5,  8'h43, 8'hD8, 3'b000, 3'b100, 3'b000, 3'd3, 2'd2, 1'b0}  // R5 count ch2 only
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic [14:0] strobes();
    return {prog_stb, latch_cnt_stb, latch_sts_stb, data_wr_stb, data_rd_stb};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {strobes(), rdata, mode_out, access_out, bcd_out}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 idle", strobes(), '0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][34:31], i);
      wr(VEC[i][30:23], VEC[i][22:15]);
      chk(tag, {prog_stb, latch_cnt_stb, latch_sts_stb}, VEC[i][14:6]);
      chk(tag, {mode_out, access_out, bcd_out}, VEC[i][5:0]);
      @(negedge clk);
      chk("R12 pulse ends", strobes(), '0);
    end

    // R8 data writes
    for (int ch = 0; ch < 3; ch++) begin
      wr(8'h40 + 8'(ch), 8'hA0 + 8'(ch));
      chk("R8 stb", data_wr_stb, 32'(1 << ch));
      chk("R8 byte", data_out, 8'hA0 + 8'(ch));
      chk("R8 no prog", {prog_stb, latch_cnt_stb, latch_sts_stb}, '0);
    end

    // R9 data reads
    chan_rdata = 24'h5A_3C_C3;
    for (int ch = 0; ch < 3; ch++) begin
      rd(8'h40 + 8'(ch));
      chk("R9 stb", data_rd_stb, 32'(1 << ch));
      chk("R9 byte", rdata, (chan_rdata >> (8 * ch)) & 8'hFF);
    end

    // R10 command read
    rd(8'h43);
    chk("R10 zero", rdata, 8'h00);
    chk("R10 no stb", strobes(), '0);

    // R11 unmapped read after a non-zero read
    rd(8'h41);
    chk("R9 reload", rdata, 8'h3C);
    rd(8'h3F);
    chk("R11 rdata", rdata, 8'h00);
    chk("R11 no stb", strobes(), '0);
    chk("R11 fields", {mode_out, access_out, bcd_out}, {3'd3, 2'd2, 1'b0});

    // R12 back-to-back program words each pulse once
    @(negedge clk); addr = 8'h43; wdata = 8'h76; wr_en = 1'b1;
    @(negedge clk); wdata = 8'hB4;
    chk("R12 first", prog_stb, 3'b010);
    @(negedge clk); wr_en = 1'b0;
    chk("R12 second", prog_stb, 3'b100);
    @(negedge clk);
    chk("R12 after", strobes(), '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule